// File: doc/BRIEF.md
# Predicated Segment Load and Broadcast Unit

This unit carries out one masked byte gather from thirty-two consecutive memory locations and assembles the bytes into a 256-bit segment. It then copies that segment across a vector register whose length is given with each command. A command supplies a 64-bit base, a flag that selects the stack pointer as the base, a signed 4-bit immediate scaled by 32, a predicate mask and the vector length in bits. The unit computes the start address and walks the lanes in ascending order. For each enabled lane it issues a single byte read over a valid/ready request channel and waits for the matching response. Disabled lanes are skipped and hold zero.

When the walk ends, the unit raises a one-cycle completion strobe. If no exception occurred, a result-valid strobe comes with it and the broadcast vector is presented. Three exception flags can be raised instead, and each one suppresses the result: a vector length too short for one segment, a misaligned stack-pointer base, and an error response on a read. A read error also reports the index of the lane that faulted.

Top module: `seg_bcast_load`

## Requirements
- R1: The segment start address is base plus the sign-extended 4-bit immediate times 32 (range -256 to +224). Lane e is read from start address plus e.
- R2: Only predicate bits 0 to 31 take part. Predicate bits 32 and above have no effect on the reads or on the result.
- R3: A lane whose predicate bit is 0 issues no read and holds byte value zero in the segment.
- R4: Reads go out in ascending lane order with at most one outstanding. A request that is not accepted keeps `rd_req_valid` high and its address unchanged until `rd_req_ready`.
- R5: The result places lane e in bits [8e+7:8e] of each 256-bit copy. Copy k occupies bits [256k+255:256k] for k below floor(vl/256). All higher result bits are zero.
- R6: A vector length below 256 completes with `exc_undef`=1, issues no read and gives no result.
- R7: With the stack pointer selected as the base, at least one active lane and base bits [3:0] not zero, the command completes with `exc_align`=1 and issues no read. The length check of R6 takes precedence over this check.
- R8: With the stack pointer selected as the base and no active lane, the alignment check of R7 is applied only when `cfg_sp_chk_idle`=1. Otherwise the command completes normally with an all-zero segment.
- R9: Every read request carries `rd_req_tagged`=1 unless the stack pointer is the base, in which case it carries 0.
- R10: An error response on a lane ends the command. The unit sets `exc_fault`=1, reports that lane on `fault_lane`, issues no further reads and gives no result.
- R11: Each accepted command produces exactly one single-cycle `done_valid`. `res_valid` is asserted only together with it and only when no exception flag is set. `cmd_ready` is high only while no command is in progress.
- R12: After reset, `cmd_ready`=1 and both `rd_req_valid` and `done_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Unit idle and accepting a command |
| cmd_base | input | 64 | Base address value |
| cmd_use_sp | input | 1 | Base is the stack pointer |
| cmd_imm | input | 4 | Signed segment offset in units of 32 bytes |
| cmd_pred | input | MAX_VL/8 | Predicate mask; bit e enables lane e |
| cmd_vl | input | VLW | Vector length in bits |
| cfg_sp_chk_idle | input | 1 | Apply the stack alignment check when no lane is active |
| rd_req_valid | output | 1 | Byte read request valid |
| rd_req_ready | input | 1 | Byte read request accepted |
| rd_req_addr | output | 64 | Byte read address |
| rd_req_tagged | output | 1 | Read is subject to tag checking |
| rd_rsp_valid | input | 1 | Read response valid |
| rd_rsp_ready | output | 1 | Unit waiting for a response |
| rd_rsp_data | input | 8 | Read response byte |
| rd_rsp_err | input | 1 | Read response reports an error |
| done_valid | output | 1 | Command complete (one cycle) |
| res_valid | output | 1 | Result valid (no exception) |
| res_data | output | MAX_VL | Broadcast result vector |
| exc_undef | output | 1 | Vector length too short |
| exc_align | output | 1 | Stack base misaligned |
| exc_fault | output | 1 | Read error response |
| fault_lane | output | 5 | Lane that received the error |

## Verification
The bench builds the unit with MAX_VL=1024, so four segment copies and a 128-bit predicate fit in the result. Vector lengths from 128 to 1023 bits then cover rejection, one to three full copies with zeroed upper bits, and lengths that are not multiples of 256. Random predicates carry random upper bits so that their lack of effect shows in the results. Random request and response latencies stress the handshake. Directed cases cover the extreme immediates, the error at lane 0 and lane 31, and every stack-base alignment combination.

// File: rtl/seg_bcast_load.sv
module seg_bcast_load #(
  parameter int MAX_VL = 2048,
  parameter int VLW    = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  output logic                cmd_ready,
  input  logic [63:0]         cmd_base,
  input  logic                cmd_use_sp,
  input  logic [3:0]          cmd_imm,
  input  logic [MAX_VL/8-1:0] cmd_pred,
  input  logic [VLW-1:0]      cmd_vl,
  input  logic                cfg_sp_chk_idle,
  output logic                rd_req_valid,
  input  logic                rd_req_ready,
  output logic [63:0]         rd_req_addr,
  output logic                rd_req_tagged,
  input  logic                rd_rsp_valid,
  output logic                rd_rsp_ready,
  input  logic [7:0]          rd_rsp_data,
  input  logic                rd_rsp_err,
  output logic                done_valid,
  output logic                res_valid,
  output logic [MAX_VL-1:0]   res_data,
  output logic                exc_undef,
  output logic                exc_align,
  output logic                exc_fault,
  output logic [4:0]          fault_lane
);
  localparam int SEGS = MAX_VL / 256;

  typedef enum logic [1:0] {S_IDLE, S_SCAN, S_WAIT, S_FIN} st_t;
  st_t st_q;

  logic [63:0]    addr_q;
  logic [31:0]    pred_q;
  logic [5:0]     lane_q;
  logic [255:0]   seg_q;
  logic [VLW-9:0] copies_q;
  logic           sp_q;

  wire accept    = cmd_valid && cmd_ready;
  wire any_act   = |cmd_pred[31:0];
  wire short_vl  = cmd_vl < VLW'(256);
  wire align_bad = cmd_use_sp && (cmd_base[3:0] != 4'd0) && (any_act || cfg_sp_chk_idle);

  assign cmd_ready     = (st_q == S_IDLE);
  assign rd_req_valid  = (st_q == S_SCAN) && !lane_q[5] && pred_q[lane_q[4:0]];
  assign rd_req_addr   = addr_q + 64'(lane_q);
  assign rd_req_tagged = !sp_q;
  assign rd_rsp_ready  = (st_q == S_WAIT);
  assign done_valid    = (st_q == S_FIN);
  assign res_valid     = done_valid && !exc_undef && !exc_align && !exc_fault;

  for (genvar g = 0; g < SEGS; g++) begin : g_copy
    assign res_data[g*256 +: 256] = (32'(copies_q) > g) ? seg_q : 256'd0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= S_IDLE;
      addr_q     <= '0;
      pred_q     <= '0;
      lane_q     <= '0;
      seg_q      <= '0;
      copies_q   <= '0;
      sp_q       <= 1'b0;
      exc_undef  <= 1'b0;
      exc_align  <= 1'b0;
      exc_fault  <= 1'b0;
      fault_lane <= '0;
    end else begin
      case (st_q)
        S_IDLE: if (accept) begin
          addr_q     <= cmd_base + {{55{cmd_imm[3]}}, cmd_imm, 5'b0};
          pred_q     <= cmd_pred[31:0];
          lane_q     <= '0;
          seg_q      <= '0;
          copies_q   <= cmd_vl[VLW-1:8];
          sp_q       <= cmd_use_sp;
          exc_undef  <= short_vl;
          exc_align  <= !short_vl && align_bad;
          exc_fault  <= 1'b0;
          fault_lane <= '0;
          st_q       <= (short_vl || align_bad) ? S_FIN : S_SCAN;
        end
        S_SCAN: begin
          if (lane_q[5])          st_q <= S_FIN;
          else if (!rd_req_valid) lane_q <= lane_q + 6'd1;
          else if (rd_req_ready)  st_q <= S_WAIT;
        end
        S_WAIT: if (rd_rsp_valid) begin
          if (rd_rsp_err) begin
            exc_fault  <= 1'b1;
            fault_lane <= lane_q[4:0];
            st_q       <= S_FIN;
          end else begin
            seg_q[lane_q[4:0]*8 +: 8] <= rd_rsp_data;
            lane_q <= lane_q + 6'd1;
            st_q   <= S_SCAN;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/seg_bcast_load_chk.sv
module seg_bcast_load_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_ready,
  input logic        rd_req_valid,
  input logic        rd_req_ready,
  input logic [63:0] rd_req_addr,
  input logic        rd_rsp_ready,
  input logic        done_valid,
  input logic        res_valid,
  input logic        exc_undef,
  input logic        exc_align,
  input logic        exc_fault
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr)); // R4
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid |-> !rd_rsp_ready); // R4
  AST_RES_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> done_valid && !exc_undef && !exc_align && !exc_fault); // R11
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> !done_valid); // R11
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !rd_req_valid && !rd_rsp_ready && !done_valid); // R11
  AST_EXC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> $onehot0({exc_undef, exc_align, exc_fault})); // R10
endmodule

bind seg_bcast_load seg_bcast_load_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready),
  .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
  .rd_rsp_ready(rd_rsp_ready), .done_valid(done_valid), .res_valid(res_valid),
  .exc_undef(exc_undef), .exc_align(exc_align), .exc_fault(exc_fault)
);

// File: tb/sim_seg_bcast_load.sv
module sim_seg_bcast_load;
  localparam int MAX_VL = 1024;
  localparam int VLW    = 12;
  localparam int PW     = MAX_VL / 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 0, cmd_ready, cmd_use_sp = 0, cfg_sp_chk_idle = 0;
  logic [63:0] cmd_base = '0;
  logic [3:0]  cmd_imm = '0;
  logic [PW-1:0] cmd_pred = '0;
  logic [VLW-1:0] cmd_vl = '0;
  logic rd_req_valid, rd_req_ready = 0, rd_req_tagged, rd_rsp_valid = 0, rd_rsp_ready, rd_rsp_err = 0;
  logic [63:0] rd_req_addr;
  logic [7:0] rd_rsp_data = '0;
  logic done_valid, res_valid, exc_undef, exc_align, exc_fault;
  logic [MAX_VL-1:0] res_data;
  logic [4:0] fault_lane;

  int n_chk = 0, n_fail = 0;

  seg_bcast_load #(.MAX_VL(MAX_VL), .VLW(VLW)) u0 (.*);

  always #4 clk = ~clk;

  // memory model
  logic pend = 0;
  logic [63:0] paddr = '0;
  logic [63:0] err_addr = '0;
  logic err_en = 0, exp_tag = 1;
  int nreq = 0, tagbad = 0;
  logic [63:0] reqlog [0:255];

  function automatic logic [7:0] mb(input logic [63:0] a);
    return a[7:0] ^ a[15:8] ^ a[39:32] ^ 8'hA5;
  endfunction

  always @(posedge clk) begin
    if (rd_req_valid && rd_req_ready) begin
      pend <= 1'b1;
      paddr <= rd_req_addr;
      reqlog[nreq[7:0]] <= rd_req_addr;
      nreq <= nreq + 1;
      if (rd_req_tagged !== exp_tag) tagbad <= tagbad + 1;
    end else if (rd_rsp_valid && rd_rsp_ready) pend <= 1'b0;
  end

  always @(negedge clk) begin
    rd_req_ready <= !pend && ($urandom % 4 != 0);
    rd_rsp_valid <= pend && ($urandom % 3 != 0);
    rd_rsp_data  <= mb(paddr);
    rd_rsp_err   <= err_en && (paddr == err_addr);
  end

  task automatic check(input bit ok, input string req, input logic [MAX_VL-1:0] act, input logic [MAX_VL-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [63:0] base, input bit sp, input logic [3:0] imm,
                        input logic [PW-1:0] pred, input logic [VLW-1:0] vl, input bit cfg,
                        input int errl, input string tag);
    logic [31:0] act = pred[31:0];
    bit undef = vl < 256;
    bit align = !undef && sp && base[3:0] != 0 && ((|act) || cfg);
    logic [63:0] a0 = base + {{55{imm[3]}}, imm, 5'b0};
    logic [255:0] seg = '0;
    logic [MAX_VL-1:0] expres = '0;
    logic [63:0] expaddr [0:31];
    int nexp = 0, flane = 0, start, tb0, wd = 0;
    bit fault = 0;
    if (!undef && !align)
      for (int e = 0; e < 32; e++)
        if (act[e] && !fault) begin
          expaddr[nexp] = a0 + 64'(e);
          nexp++;
          if (e == errl) begin fault = 1; flane = e; end
          else seg[e*8 +: 8] = mb(a0 + 64'(e));
        end
    for (int k = 0; k < MAX_VL/256; k++)
      if (k < int'(vl) / 256) expres[k*256 +: 256] = seg;
    err_en = (errl >= 0);
    err_addr = a0 + 64'(errl);
    exp_tag = !sp;
    start = nreq; tb0 = tagbad;
    cmd_base = base; cmd_use_sp = sp; cmd_imm = imm; cmd_pred = pred;
    cmd_vl = vl; cfg_sp_chk_idle = cfg; cmd_valid = 1;
    @(posedge clk); @(negedge clk);
    cmd_valid = 0;
    cmd_pred = {PW/32{$urandom}};
    while (!done_valid && wd < 2000) begin @(negedge clk); wd++; end
    check(done_valid, {"R11 done ", tag}, MAX_VL'(done_valid), 1);
    check(exc_undef == undef, {"R6 undef ", tag}, MAX_VL'(exc_undef), MAX_VL'(undef));
    check(exc_align == align, {"R7 R8 align ", tag}, MAX_VL'(exc_align), MAX_VL'(align));
    check(exc_fault == fault, {"R10 fault ", tag}, MAX_VL'(exc_fault), MAX_VL'(fault));
    if (fault) check(fault_lane == 5'(flane), {"R10 lane ", tag}, MAX_VL'(fault_lane), MAX_VL'(flane));
    check(res_valid == (!undef && !align && !fault), {"R11 res_valid ", tag}, MAX_VL'(res_valid), MAX_VL'(!undef && !align && !fault));
    if (res_valid) check(res_data == expres, {"R5 R3 R2 data ", tag}, res_data, expres);
    check(nreq - start == nexp, {"R3 R6 R7 read count ", tag}, MAX_VL'(nreq - start), MAX_VL'(nexp));
    for (int i = 0; i < nexp && i < nreq - start; i++)
      check(reqlog[8'(start + i)] == expaddr[i], {"R1 R4 address ", tag}, MAX_VL'(reqlog[8'(start + i)]), MAX_VL'(expaddr[i]));
    check(tagbad == tb0, {"R9 tag ", tag}, MAX_VL'(tagbad - tb0), 0);
    @(negedge clk);
    check(!done_valid, {"R11 single done ", tag}, MAX_VL'(done_valid), 0);
  endtask

  function automatic logic [PW-1:0] rpred();
    logic [PW-1:0] p;
    for (int i = 0; i < PW/32; i++) p[i*32 +: 32] = $urandom;
    return p;
  endfunction

  initial begin
    #(8 * 190000);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(cmd_ready && !rd_req_valid && !done_valid, "R12 reset state",
          MAX_VL'({cmd_ready, rd_req_valid, done_valid}), MAX_VL'(3'b100));
    run_op(64'h1000, 0, 4'h0, '1, 12'd1024, 0, -1, "all active");
    run_op(64'h2000, 0, 4'h8, {{(PW-32){1'b1}}, 32'h0}, 12'd768, 0, -1, "upper only R2");
    run_op(64'h3000, 0, 4'h7, {PW/32{32'h8000_0001}}, 12'd512, 0, -1, "imm max");
    run_op(64'h40, 0, 4'h8, '1, 12'd256, 0, -1, "imm min wrap");
    run_op(64'h5000, 0, 4'h0, '1, 12'd128, 0, -1, "vl 128");
    run_op(64'h5000, 1, 4'h0, '1, 12'd255, 1, -1, "vl 255 sp");
    run_op(64'h6004, 1, 4'h0, 32'h10, 12'd512, 0, -1, "sp misaligned");
    run_op(64'h6004, 1, 4'h0, '0, 12'd512, 0, -1, "sp idle nochk");
    run_op(64'h6004, 1, 4'h0, '0, 12'd512, 1, -1, "sp idle chk");
    run_op(64'h6010, 1, 4'h3, 32'hF0F0_0F0F, 12'd640, 1, -1, "sp aligned");
    run_op(64'h7000, 0, 4'h1, '1, 12'd1023, 0, 0, "err lane0");
    run_op(64'h7000, 0, 4'h1, '1, 12'd1023, 0, 31, "err lane31");
    run_op(64'h7000, 0, 4'h1, 32'h0000_FF00, 12'd512, 0, 3, "err inactive");
    for (int i = 0; i < 200; i++) begin
      logic [63:0] b = {$urandom, $urandom};
      bit sp = ($urandom % 4 == 0);
      if (sp && ($urandom % 2 == 0)) b[3:0] = 0;
      run_op(b, sp, 4'($urandom), rpred(), VLW'(128 + $urandom % 896), 1'($urandom),
             ($urandom % 4 == 0) ? int'($urandom % 32) : -1, "random");
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule